// File: doc/BRIEF.md
# Bus-Master DMA Channel Register File

This block is the register file in front of a two-channel bus-master disk DMA engine. It sits in a 16-byte I/O window. The window holds one 8-byte bank per channel, and the channel is picked by address bit 3. Each bank has a command byte, a status byte and a 32-bit descriptor-table pointer. Software accesses the window as bytes, halfwords or words. Write data is right-aligned and lands at the addressed byte. Read data returns right-aligned one cycle after the request.

The block does not move data. It tells a separate transfer engine when a channel must start or abort, using one-cycle pulses per channel. It also shows the engine the transfer direction and a current-address copy of the pointer. The engine reports the end of a transfer, or a fault, with one-cycle set pulses. These pulses update the status byte.

Offsets 1 and 3 of each bank are reserved for a vendor extension. With the extension parameter off, they read as all ones and ignore writes.

Top module: `bmdma_regfile`

## Requirements
- R1: Address bit 3 selects the channel bank. Inside a bank, byte 0 is command, byte 2 is status and bytes 4 to 7 are the pointer (least significant byte at 4). A read returns the bank bytes starting at the addressed one, right-aligned and cut to the access size. The size encoding is 0 for byte, 1 for halfword and 2 for word. Bytes past the end of the bank read as zero.
- R2: A command write stores only bit 0 (start) and bit 3 (direction); every other command bit reads as 0. The `eng_dir` output follows the stored bit 3.
- R3: A command write with bit 0 clear raises that channel's `eng_cancel` for exactly one cycle.
- R4: A command write with bit 0 set while status bit 0 (active) is clear sets active and raises `eng_start` for one cycle. If active is already set, no start pulse is produced.
- R5: A status write replaces bits 6 and 5 with the written value. It clears bit 1 and bit 2 where the written value has a 1. It leaves bit 0 alone. Bits 7, 4 and 3 always read 0.
- R6: A pointer write of any size changes only the addressed bytes, with the byte data taken from the low end of the write data. Pointer bits 1:0 always read 0.
- R7: Every pointer write also loads the same value into the channel's current-address output.
- R8: With the vendor extension off, bytes 1 and 3 of each bank read as 0xFF and writes to them change nothing.
- R9: An engine error pulse sets status bit 1 and an engine done pulse sets status bit 2. Either pulse clears status bit 0. A pulse wins over a same-cycle software clear of the same bit.
- R10: Reset clears command, status and pointer of every channel. `eng_cancel` is high on every channel for as long as reset is applied.
- R11: `rd_data` changes only in the cycle after a read request. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request this cycle |
| rd_en | input | 1 | Read request this cycle |
| addr | input | ADDR_W (4) | Byte address in the window |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata | input | 32 | Right-aligned write data |
| rd_data | output | 32 | Right-aligned read data, one cycle after rd_en |
| eng_start | output | NUM_CH | Per-channel start pulse to the engine |
| eng_cancel | output | NUM_CH | Per-channel cancel pulse to the engine |
| eng_dir | output | NUM_CH | Per-channel direction bit from command bit 3 |
| eng_err_set | input | NUM_CH | Engine pulse: set error, drop active |
| eng_irq_set | input | NUM_CH | Engine pulse: set done, drop active |
| cur_addr | output | NUM_CH*32 | Current-address copies, channel 0 in the low word |

## Verification
The bench writes the pointer with all three sizes and at every byte offset, including word writes that run past the end of the bank. This separates correct lane placement and alignment masking from shifted or truncated writes. It sends command bytes with extra bits set and with start both set and clear, once while the channel is idle and once while it is active. This tells a start pulse from a cancel pulse and shows whether a repeated start is suppressed. It writes status with all ones and all zeros to separate the read/write bits from the write-one-to-clear bits and the protected active bit. It also lines up an engine pulse with a software clear of the same bit, so the priority rule can be observed.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BANK_BYTES = 8;
  localparam int PTR_W      = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // byte positions inside a bank (decoded by software, so fixed)
  localparam int OFS_CMD   = 0;
  localparam int OFS_VND_A = 1;
  localparam int OFS_STS   = 2;
  localparam int OFS_VND_B = 3;
  localparam int OFS_PTR   = 4;

  // command / status bit layout
  localparam logic [7:0] CMD_KEEP    = 8'h09;
  localparam int         ST_ACT      = 0;
  localparam int         ST_ERR      = 1;
  localparam int         ST_DONE     = 2;
  localparam logic [7:0] ST_RW_MASK  = 8'h60;
  localparam logic [7:0] ST_W1C_MASK = 8'h06;
  localparam logic [7:0] VND_IDLE    = 8'hFF;
endpackage

// File: rtl/bmdma_lane_dec.sv
module bmdma_lane_dec
  import bmdma_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        ofs,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output logic [7:0]        lane_we,
  output logic [7:0][7:0]   lane_wd
);
  localparam int MAX_BYTES = DATA_W / 8;

  always_comb begin
    int nbytes;
    case (size)
      SZ_BYTE: nbytes = 1;
      SZ_HALF: nbytes = 2;
      default: nbytes = MAX_BYTES;
    endcase
    for (int k = 0; k < BANK_BYTES; k++) begin
      int rel;
      rel        = k - int'(ofs);
      lane_we[k] = 1'b0;
      lane_wd[k] = '0;
      if (rel >= 0 && rel < nbytes) begin
        lane_we[k] = 1'b1;
        lane_wd[k] = wdata[8*rel +: 8];
      end
    end
  end
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel
  import bmdma_pkg::*;
#(
  parameter bit VENDOR_EXT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_wr,
  input  logic [7:0]       lane_we,
  input  logic [7:0][7:0]  lane_wd,
  input  logic             err_set,
  input  logic             irq_set,
  output logic [63:0]      image,
  output logic             start_p,
  output logic             cancel_p,
  output logic             dir,
  output logic [PTR_W-1:0] cur_addr
);
  logic [7:0]       cmd_q, sts_q, sts_d, vnd_a_q, vnd_b_q;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             cmd_wr, sts_wr, ptr_wr, go_req, stop_req;

  assign cmd_wr   = sel_wr & lane_we[OFS_CMD];
  assign sts_wr   = sel_wr & lane_we[OFS_STS];
  assign ptr_wr   = sel_wr & (|lane_we[OFS_PTR +: 4]);
  assign go_req   = cmd_wr &  lane_wd[OFS_CMD][0] & ~sts_q[ST_ACT];
  assign stop_req = cmd_wr & ~lane_wd[OFS_CMD][0];

  // status next state: software write, then engine pulses, then start
  always_comb begin
    sts_d = sts_q;
    if (sts_wr)
      sts_d = (sts_q & ~(ST_RW_MASK | (lane_wd[OFS_STS] & ST_W1C_MASK)))
            | (lane_wd[OFS_STS] & ST_RW_MASK);
    if (err_set | irq_set) sts_d[ST_ACT] = 1'b0;
    if (err_set)           sts_d[ST_ERR]  = 1'b1;
    if (irq_set)           sts_d[ST_DONE] = 1'b1;
    if (go_req)            sts_d[ST_ACT] = 1'b1;
  end

  // pointer lanes merge, alignment forced afterwards
  always_comb begin
    for (int b = 0; b < 4; b++)
      ptr_d[8*b +: 8] = (sel_wr && lane_we[OFS_PTR+b]) ? lane_wd[OFS_PTR+b]
                                                       : ptr_q[8*b +: 8];
    ptr_d[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      sts_q    <= '0;
      ptr_q    <= '0;
      cur_addr <= '0;
      vnd_a_q  <= VND_IDLE;
      vnd_b_q  <= VND_IDLE;
      start_p  <= 1'b0;
      cancel_p <= 1'b1;
    end else begin
      if (cmd_wr) cmd_q <= lane_wd[OFS_CMD] & CMD_KEEP;
      sts_q <= sts_d;
      ptr_q <= ptr_d;
      if (ptr_wr) cur_addr <= ptr_d;
      if (VENDOR_EXT && sel_wr && lane_we[OFS_VND_A]) vnd_a_q <= lane_wd[OFS_VND_A];
      if (VENDOR_EXT && sel_wr && lane_we[OFS_VND_B]) vnd_b_q <= lane_wd[OFS_VND_B];
      start_p  <= go_req;
      cancel_p <= stop_req;
    end
  end

  assign dir   = cmd_q[3];
  assign image = {ptr_q, vnd_b_q, sts_q, vnd_a_q, cmd_q};
endmodule

// File: rtl/bmdma_regfile.sv
module bmdma_regfile
  import bmdma_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter bit VENDOR_EXT = 1'b0,
  localparam int ADDR_W    = $clog2(NUM_CH) + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [1:0]              acc_size,
  input  logic [31:0]             wdata,
  output logic [31:0]             rd_data,
  output logic [NUM_CH-1:0]       eng_start,
  output logic [NUM_CH-1:0]       eng_cancel,
  output logic [NUM_CH-1:0]       eng_dir,
  input  logic [NUM_CH-1:0]       eng_err_set,
  input  logic [NUM_CH-1:0]       eng_irq_set,
  output logic [NUM_CH*PTR_W-1:0] cur_addr
);
  localparam int CH_W = $clog2(NUM_CH);

  logic [7:0]          lane_we;
  logic [7:0][7:0]     lane_wd;
  logic [63:0]         bank_img [NUM_CH];
  logic [NUM_CH*64-1:0] bank_flat;
  logic [CH_W-1:0]     ch_sel;
  logic [63:0]         rd_img;
  logic [31:0]         rd_sh, rd_next;

  assign ch_sel = addr[ADDR_W-1:3];

  bmdma_lane_dec #(.DATA_W(32)) u_lanes (
    .ofs     (addr[2:0]),
    .size    (acc_size),
    .wdata   (wdata),
    .lane_we (lane_we),
    .lane_wd (lane_wd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    bmdma_channel #(.VENDOR_EXT(VENDOR_EXT)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .sel_wr   (wr_en && (ch_sel == CH_W'(c))),
      .lane_we  (lane_we),
      .lane_wd  (lane_wd),
      .err_set  (eng_err_set[c]),
      .irq_set  (eng_irq_set[c]),
      .image    (bank_img[c]),
      .start_p  (eng_start[c]),
      .cancel_p (eng_cancel[c]),
      .dir      (eng_dir[c]),
      .cur_addr (cur_addr[c*PTR_W +: PTR_W])
    );
    assign bank_flat[c*64 +: 64] = bank_img[c];
  end

  always_comb begin
    rd_img = bank_img[ch_sel];
    rd_sh  = 32'(rd_img >> {addr[2:0], 3'b000});
    case (acc_size)
      SZ_BYTE: rd_next = {24'h0, rd_sh[7:0]};
      SZ_HALF: rd_next = {16'h0, rd_sh[15:0]};
      default: rd_next = rd_sh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_next;
  end
endmodule

// File: rtl/bmdma_regfile_chk.sv
module bmdma_regfile_chk #(
  parameter int NUM_CH     = 2,
  parameter bit VENDOR_EXT = 1'b0,
  parameter int ADDR_W     = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  rd_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [1:0]            acc_size,
  input logic [31:0]           rd_data,
  input logic [NUM_CH-1:0]     eng_start,
  input logic [NUM_CH-1:0]     eng_cancel,
  input logic [NUM_CH-1:0]     eng_err_set,
  input logic [NUM_CH-1:0]     eng_irq_set,
  input logic [NUM_CH*32-1:0]  cur_addr,
  input logic [NUM_CH*64-1:0]  bank_flat
);
  p_reset_cancel_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (eng_cancel == {NUM_CH{1'b1}}));

  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> $stable(rd_data));

  if (!VENDOR_EXT) begin : g_vnd
    p_vendor_ff_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rd_en && acc_size == 2'd0 && addr[2:0] == 3'd1) |-> (rd_data == 32'hFF));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    p_start_cancel_excl_r3: assert property (@(posedge clk) disable iff (rst)
      !(eng_start[c] && eng_cancel[c]));

    p_start_needs_idle_r4: assert property (@(posedge clk) disable iff (rst)
      eng_start[c] |-> (bank_flat[c*64+16] && !$past(bank_flat[c*64+16])));

    p_err_sets_r9: assert property (@(posedge clk) disable iff (rst)
      eng_err_set[c] |=> bank_flat[c*64+17]);

    p_irq_sets_r9: assert property (@(posedge clk) disable iff (rst)
      eng_irq_set[c] |=> bank_flat[c*64+18]);

    p_cur_match_r7: assert property (@(posedge clk) disable iff (rst)
      cur_addr[c*32 +: 32] == bank_flat[c*64+32 +: 32]);

    p_ptr_align_r6: assert property (@(posedge clk) disable iff (rst)
      cur_addr[c*32 +: 2] == 2'b00);
  end
endmodule

bind bmdma_regfile bmdma_regfile_chk #(
  .NUM_CH(NUM_CH), .VENDOR_EXT(VENDOR_EXT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .acc_size(acc_size),
  .rd_data(rd_data), .eng_start(eng_start), .eng_cancel(eng_cancel),
  .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set),
  .cur_addr(cur_addr), .bank_flat(bank_flat)
);

// File: tb/tb_bmdma_regfile.sv
`timescale 1ns/1ps
module tb_bmdma_regfile;
  localparam int WD_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [1:0]  eng_start, eng_cancel, eng_dir;
  logic [1:0]  eng_err_set = '0, eng_irq_set = '0;
  logic [63:0] cur_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bmdma_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .acc_size(acc_size), .wdata(wdata), .rd_data(rd_data),
    .eng_start(eng_start), .eng_cancel(eng_cancel), .eng_dir(eng_dir),
    .eng_err_set(eng_err_set), .eng_irq_set(eng_irq_set), .cur_addr(cur_addr)
  );

  // reference model state
  logic [7:0]  m_cmd [2];
  logic [7:0]  m_sts [2];
  logic [31:0] m_ptr [2];
  logic [31:0] m_cur [2];
  logic [31:0] exp_rd = '0;

  function automatic logic [63:0] img(int ch);
    return {m_ptr[ch], 8'hFF, m_sts[ch], 8'hFF, m_cmd[ch]};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit r, int a, int sz, logic [31:0] d,
                     logic [1:0] es, logic [1:0] is, string tag);
    int ch, ofs, nb;
    logic [7:0]  n_cmd [2];
    logic [7:0]  n_sts [2];
    logic [31:0] n_ptr [2];
    logic [1:0]  e_start, e_cancel, go;
    logic [63:0] sh;
    ch = a >> 3; ofs = a & 7;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    wr_en = w; rd_en = r; addr = 4'(a); acc_size = 2'(sz); wdata = d;
    eng_err_set = es; eng_irq_set = is;
    if (r) begin
      sh = img(ch) >> (8 * ofs);
      exp_rd = (nb == 1) ? {24'h0, sh[7:0]} : (nb == 2) ? {16'h0, sh[15:0]} : sh[31:0];
    end
    for (int c = 0; c < 2; c++) begin
      n_cmd[c] = m_cmd[c]; n_sts[c] = m_sts[c]; n_ptr[c] = m_ptr[c];
    end
    e_start = '0; e_cancel = '0; go = '0;
    if (w) begin
      for (int i = 0; i < nb; i++) begin
        int pos;
        logic [7:0] b;
        pos = ofs + i;
        b = d[8*i +: 8];
        if (pos == 0) begin
          n_cmd[ch] = b & 8'h09;
          if (!b[0]) e_cancel[ch] = 1'b1;
          else if (!m_sts[ch][0]) begin e_start[ch] = 1'b1; go[ch] = 1'b1; end
        end else if (pos == 2) begin
          n_sts[ch][6:5] = b[6:5];
          n_sts[ch][2:1] = n_sts[ch][2:1] & ~b[2:1];
        end else if (pos >= 4 && pos <= 7) begin
          n_ptr[ch][8*(pos-4) +: 8] = b;
        end
      end
      n_ptr[ch][1:0] = 2'b00;
    end
    for (int c = 0; c < 2; c++) begin
      if (es[c] || is[c]) n_sts[c][0] = 1'b0;
      if (es[c]) n_sts[c][1] = 1'b1;
      if (is[c]) n_sts[c][2] = 1'b1;
      if (go[c]) n_sts[c][0] = 1'b1;
    end
    @(posedge clk); #1;
    for (int c = 0; c < 2; c++) begin
      if (w && c == ch && (ofs + nb > 4)) m_cur[c] = n_ptr[c];
      m_cmd[c] = n_cmd[c]; m_sts[c] = n_sts[c]; m_ptr[c] = n_ptr[c];
    end
    chk({"R4 start pulse / ", tag}, 64'(eng_start), 64'(e_start));
    chk({"R3 cancel pulse / ", tag}, 64'(eng_cancel), 64'(e_cancel));
    chk({"R2 direction / ", tag}, 64'(eng_dir), 64'({m_cmd[1][3], m_cmd[0][3]}));
    chk({"R7 current address / ", tag}, 64'(cur_addr), {m_cur[1], m_cur[0]});
    chk({"R11 read data / ", tag}, 64'(rd_data), 64'(exp_rd));
    wr_en = 1'b0; rd_en = 1'b0; eng_err_set = '0; eng_irq_set = '0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      m_cmd[c] = '0; m_sts[c] = '0; m_ptr[c] = '0; m_cur[c] = '0;
    end
    // R10: cancel held on every channel during reset
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R10 cancel during reset", 64'(eng_cancel), 64'h3);
    end
    rst = 1'b0;
    // R10: all registers clear after reset
    cyc(0, 1, 0,  2, 0, 0, 0, "R10 ch0 low word");
    cyc(0, 1, 4,  2, 0, 0, 0, "R10 ch0 pointer");
    cyc(0, 1, 8,  2, 0, 0, 0, "R10 ch1 low word");
    cyc(0, 1, 12, 2, 0, 0, 0, "R10 ch1 pointer");
    // R1: channel map and read lanes
    cyc(1, 0, 12, 2, 32'h12345678, 0, 0, "R1 ch1 pointer write");
    cyc(0, 1, 12, 2, 0, 0, 0, "R1 ch1 pointer read");
    cyc(0, 1, 4,  2, 0, 0, 0, "R1 ch0 untouched");
    cyc(0, 1, 13, 0, 0, 0, 0, "R1 byte lane read");
    cyc(0, 1, 14, 1, 0, 0, 0, "R1 halfword lane read");
    cyc(0, 1, 14, 2, 0, 0, 0, "R1 word past bank end");
    // R6: sub-word pointer writes and alignment
    cyc(1, 0, 4, 0, 32'h000000FF, 0, 0, "R6 byte at 4");
    cyc(0, 1, 4, 2, 0, 0, 0, "R6 read after byte 4");
    cyc(1, 0, 7, 0, 32'h000000AB, 0, 0, "R6 byte at 7");
    cyc(1, 0, 5, 1, 32'h0000BEEF, 0, 0, "R6 half at 5");
    cyc(0, 1, 4, 2, 0, 0, 0, "R6 read after half");
    cyc(1, 0, 6, 2, 32'hCAFE1234, 0, 0, "R6 word at 6 clipped");
    cyc(0, 1, 4, 2, 0, 0, 0, "R6 read after clipped word");
    cyc(1, 1, 4, 2, 32'hFFFFFFFF, 0, 0, "R11 read during write");
    cyc(0, 1, 4, 2, 0, 0, 0, "R6 word all ones");
    cyc(1, 0, 4, 1, 32'h00000007, 0, 0, "R6 half at 4");
    cyc(0, 1, 4, 0, 0, 0, 0, "R6 low byte aligned");
    // R2 / R4: command mask and start
    cyc(1, 0, 0, 0, 32'hFF, 0, 0, "R2 command all ones");
    cyc(0, 1, 0, 0, 0, 0, 0, "R2 command readback");
    cyc(1, 0, 0, 0, 32'h01, 0, 0, "R4 start while active");
    cyc(0, 1, 2, 0, 0, 0, 0, "R4 active set");
    // R9: engine done pulse
    cyc(0, 0, 0, 0, 0, 2'b00, 2'b01, "R9 done pulse ch0");
    cyc(0, 1, 2, 0, 0, 0, 0, "R9 status after done");
    cyc(1, 0, 0, 0, 32'h01, 0, 0, "R4 restart after done");
    // R3: cancel on ch1 with direction
    cyc(1, 0, 8, 0, 32'h08, 0, 0, "R3 stop ch1 with dir");
    cyc(0, 1, 8, 0, 0, 0, 0, "R2 ch1 command readback");
    // R5: status write rules
    cyc(1, 0, 2, 0, 32'hFF, 0, 0, "R5 status all ones");
    cyc(0, 1, 2, 0, 0, 0, 0, "R5 status after ones");
    cyc(1, 0, 2, 0, 32'h00, 0, 0, "R5 status all zeros");
    cyc(0, 1, 2, 0, 0, 0, 0, "R5 status after zeros");
    // R9: set wins over W1C, other channel pulse
    cyc(1, 0, 2, 0, 32'h02, 2'b11, 2'b00, "R9 set beats clear");
    cyc(0, 1, 2, 0, 0, 0, 0, "R9 ch0 status");
    cyc(0, 1, 10, 0, 0, 0, 0, "R9 ch1 status");
    cyc(1, 0, 10, 0, 32'h06, 0, 0, "R5 clear ch1 flags");
    cyc(0, 1, 10, 0, 0, 0, 0, "R5 ch1 flags cleared");
    // R8: vendor bytes disabled
    cyc(1, 0, 1,  0, 32'h55, 0, 0, "R8 write vendor A");
    cyc(1, 0, 11, 0, 32'hAA, 0, 0, "R8 write vendor B ch1");
    cyc(0, 1, 1,  0, 0, 0, 0, "R8 vendor A read");
    cyc(0, 1, 11, 0, 0, 0, 0, "R8 vendor B read");
    cyc(0, 1, 0,  2, 0, 0, 0, "R8 ch0 low word");
    // R11: idle cycles keep read data
    cyc(0, 0, 0, 0, 0, 0, 0, "R11 hold 1");
    cyc(0, 0, 5, 2, 0, 0, 0, "R11 hold 2");
    summary();
    $finish;
  end
endmodule